// File: doc/BRIEF.md
# Dual Alarm Interrupt Controller

This block holds two time-of-day alarms and checks each one against the current BCD time held by a separate timekeeping block. Each alarm has four byte registers: seconds, minutes, hours and day. Bit 7 of each alarm byte is a mask bit. A set mask bit takes that field out of the comparison, and the mix of mask bits sets how often the alarm repeats. When an alarm matches, its status flag is set. Software can only clear a flag. It does so by writing 0 to the flag, or by pointing a transaction at one of that alarm's registers.

Two active-low interrupt outputs are driven from the flags and the enables in the control register. A routing bit selects one of two arrangements. In the first, each alarm has its own output. In the second, both alarms share the first output. A square-wave bit replaces the second interrupt output with a 32 kHz clock supplied from outside.

A small sequencer follows the 1 Hz tick. In state SEQ_WAIT it watches for a tick. A tick moves it to SEQ_COMPARE for exactly one cycle, which lets the timekeeper's registers settle. It then returns to SEQ_WAIT whatever the inputs are. Comparison happens only in SEQ_COMPARE, so a match raises its flag once per tick, and a time that does not change cannot trigger the alarm again.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After reset, the control register (address 0x0F) reads 0x80 and the status register (address 0x10) reads 0x80. Both irq0_n and irq1_n are 1.
- R2: Alarm 0 bytes at addresses 0x07–0x0A and alarm 1 bytes at 0x0B–0x0E read back the value written. Within each alarm the field order is seconds, minutes, hours, day. Control bit 6 always reads 0. Addresses outside 0x07–0x10 read 0x00.
- R3: A tick sampled on one clock edge causes a comparison on the next edge, and a matching alarm's flag reads 1 after that edge. Without a tick no flag is set, and while the time stays unchanged a cleared flag stays 0.
- R4: With all four mask bits set, the alarm matches on every tick.
- R5: A field whose mask bit is 0 matches only if its bits [6:0] equal the time byte's bits [6:0]. Masks 1110, 1100, 1000 and 0000 (listed day, hours, minutes, seconds) therefore compare seconds; minutes and seconds; hours, minutes and seconds; and all four fields.
- R6: A match sets status bit 0 (alarm 0) or bit 1 (alarm 1) even when the matching enable is 0.
- R7: Writing status bit 0, bit 1 or bit 7 (oscillator-stop flag) as 0 clears that bit. Writing it as 1 leaves it unchanged.
- R8: A pointer load (reg_ptr_load) to any address of an alarm clears that alarm's flag and leaves the other alarm's flag unchanged.
- R9: The control register bits are: bit 0 enables alarm 0, bit 1 enables alarm 1, bit 2 selects separate outputs. With bit 2 = 1, irq0_n is 0 exactly when flag 0 and enable 0 are both 1, and irq1_n is 0 exactly when flag 1 and enable 1 are both 1.
- R10: With control bit 2 = 0, irq0_n is 0 when either alarm has both its flag and its enable set, and irq1_n is 1.
- R11: With control bit 3 = 1, irq1_n equals sq_in.
- R12: A match that lands on the same edge as a clear request leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse when the time registers update |
| tm_sec | input | 8 | Current seconds, BCD |
| tm_min | input | 8 | Current minutes, BCD |
| tm_hour | input | 8 | Current hours, BCD with mode bits |
| tm_day | input | 8 | Current day of week |
| reg_wr | input | 1 | Register write strobe |
| reg_ptr_load | input | 1 | Pulse when a transaction loads its address pointer with reg_addr |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| sq_in | input | 1 | 32 kHz square-wave source |
| irq0_n | output | 1 | Active-low interrupt 0 |
| irq1_n | output | 1 | Active-low interrupt 1 or square wave |

## Verification
If a flag is stored wrongly, it shows one cycle later: the status byte reads wrong, and whenever the flag's enable is set, the affected interrupt pin is also wrong. If the sequencer compares in the wrong cycle, or compares twice, the flag rises on the wrong edge or comes back after a clear, with the time unchanged. A stored alarm byte or mask bit that is wrong shows at the next tick, which either matches when it should not or misses a match. The reference model in the bench compares the read data and both pins on every clock, so each of these faults is seen in the first cycle in which it can be observed.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
    localparam int BYTE_W      = 8;
    localparam int NUM_ALARMS  = 2;
    localparam int NUM_FIELDS  = 4;
    localparam int ALARM_BASE  = 7;
    localparam int CTRL_ADDR   = 15;
    localparam int STAT_ADDR   = 16;
    localparam logic [BYTE_W-1:0] CTRL_RESET = 8'h80;
    localparam logic [BYTE_W-1:0] CTRL_WMASK = 8'hBF;

    typedef enum logic [0:0] {
        SEQ_WAIT    = 1'b0,
        SEQ_COMPARE = 1'b1
    } seq_state_t;
endpackage

// File: rtl/alarm_match.sv
module alarm_match
    import alarm_irq_pkg::*;
#(
    parameter int NF = NUM_FIELDS
) (
    input  logic [NF*BYTE_W-1:0] alarm_bytes,
    input  logic [NF*BYTE_W-1:0] time_bytes,
    output logic                 hit
);
    logic [NF-1:0] field_ok;

    for (genvar f = 0; f < NF; f++) begin : g_field
        assign field_ok[f] = alarm_bytes[f*BYTE_W + BYTE_W - 1] ||
            (alarm_bytes[f*BYTE_W +: BYTE_W-1] == time_bytes[f*BYTE_W +: BYTE_W-1]);
    end

    assign hit = &field_ok;
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
    import alarm_irq_pkg::*;
#(
    parameter int AW = 5,
    parameter int NA = NUM_ALARMS,
    parameter int NF = NUM_FIELDS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic                    reg_ptr_load,
    input  logic [AW-1:0]           reg_addr,
    input  logic [BYTE_W-1:0]       reg_wdata,
    input  logic [NA-1:0]           set_req,
    output logic [NA*NF*BYTE_W-1:0] alarm_bytes,
    output logic [BYTE_W-1:0]       ctrl_q,
    output logic [NA-1:0]           flags_q,
    output logic [BYTE_W-1:0]       reg_rdata
);
    localparam int NREG = NA * NF;
    localparam int IW   = $clog2(NREG);

    logic [BYTE_W-1:0] mem_q [NREG];
    logic              osf_q;
    logic [AW-1:0]     off;
    logic              is_alarm, stat_wr, ctrl_wr;
    logic [NA-1:0]     in_rng, clr_req;

    assign off      = reg_addr - AW'(ALARM_BASE);
    assign is_alarm = (reg_addr >= AW'(ALARM_BASE)) && (int'(off) < NREG);
    assign stat_wr  = reg_wr && (reg_addr == AW'(STAT_ADDR));
    assign ctrl_wr  = reg_wr && (reg_addr == AW'(CTRL_ADDR));

    for (genvar a = 0; a < NA; a++) begin : g_alarm
        assign in_rng[a]  = is_alarm && ((int'(off) / NF) == a);
        assign clr_req[a] = (stat_wr && !reg_wdata[a]) || (reg_ptr_load && in_rng[a]);
    end

    for (genvar i = 0; i < NREG; i++) begin : g_pack
        assign alarm_bytes[i*BYTE_W +: BYTE_W] = mem_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
            ctrl_q  <= CTRL_RESET;
            osf_q   <= 1'b1;
            flags_q <= '0;
        end else begin
            if (reg_wr && is_alarm) mem_q[off[IW-1:0]] <= reg_wdata;
            if (ctrl_wr) ctrl_q <= reg_wdata & CTRL_WMASK;
            if (stat_wr && !reg_wdata[BYTE_W-1]) osf_q <= 1'b0;
            for (int a = 0; a < NA; a++) begin
                if (set_req[a])      flags_q[a] <= 1'b1;
                else if (clr_req[a]) flags_q[a] <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (is_alarm)
            reg_rdata = mem_q[off[IW-1:0]];
        else if (reg_addr == AW'(CTRL_ADDR))
            reg_rdata = ctrl_q;
        else if (reg_addr == AW'(STAT_ADDR))
            reg_rdata = {osf_q, {(BYTE_W-1-NA){1'b0}}, flags_q};
    end

    AST_WR_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !reg_wdata[0] && !set_req[0]) |=> !flags_q[0]); // R7
    AST_PTR_CLEARS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ptr_load && in_rng[1] && !set_req[1]) |=> !flags_q[1]); // R8
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        set_req[0] |=> flags_q[0]); // R12
endmodule

// File: rtl/irq_route.sv
module irq_route
    import alarm_irq_pkg::*;
(
    input  logic [BYTE_W-1:0] ctrl_q,
    input  logic [1:0]        flags_q,
    input  logic              sq_in,
    output logic              irq0_n,
    output logic              irq1_n
);
    logic act0, act1, split, sqw_en;

    assign act0   = flags_q[0] && ctrl_q[0];
    assign act1   = flags_q[1] && ctrl_q[1];
    assign split  = ctrl_q[2];
    assign sqw_en = ctrl_q[3];

    always_comb begin
        irq0_n = split ? !act0 : !(act0 || act1);
        if (sqw_en)     irq1_n = sq_in;
        else if (split) irq1_n = !act1;
        else            irq1_n = 1'b1;
    end
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [BYTE_W-1:0] tm_sec,
    input  logic [BYTE_W-1:0] tm_min,
    input  logic [BYTE_W-1:0] tm_hour,
    input  logic [BYTE_W-1:0] tm_day,
    input  logic              reg_wr,
    input  logic              reg_ptr_load,
    input  logic [AW-1:0]     reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              sq_in,
    output logic              irq0_n,
    output logic              irq1_n
);
    localparam int NA = NUM_ALARMS;
    localparam int NF = NUM_FIELDS;
    localparam int AB = NF * BYTE_W;

    seq_state_t             state_q, state_d;
    logic                   eval;
    logic [NA-1:0]          hit, set_req, flags_q;
    logic [NA*AB-1:0]       alarm_bytes;
    logic [AB-1:0]          time_bytes;
    logic [BYTE_W-1:0]      ctrl_q;

    assign time_bytes = {tm_day, tm_hour, tm_min, tm_sec};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        eval    = 1'b0;
        unique case (state_q)
            SEQ_WAIT:    if (tick) state_d = SEQ_COMPARE;
            SEQ_COMPARE: begin
                eval    = 1'b1;
                state_d = SEQ_WAIT;
            end
            default:     state_d = SEQ_WAIT;
        endcase
    end

    for (genvar a = 0; a < NA; a++) begin : g_cmp
        alarm_match #(.NF(NF)) u_match (
            .alarm_bytes (alarm_bytes[a*AB +: AB]),
            .time_bytes  (time_bytes),
            .hit         (hit[a])
        );
        assign set_req[a] = eval && hit[a];
    end

    alarm_regs #(.AW(AW), .NA(NA), .NF(NF)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_ptr_load (reg_ptr_load),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .set_req      (set_req),
        .alarm_bytes  (alarm_bytes),
        .ctrl_q       (ctrl_q),
        .flags_q      (flags_q),
        .reg_rdata    (reg_rdata)
    );

    irq_route u_route (
        .ctrl_q  (ctrl_q),
        .flags_q (flags_q),
        .sq_in   (sq_in),
        .irq0_n  (irq0_n),
        .irq1_n  (irq1_n)
    );

    AST_COMPARE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_COMPARE) |-> $past(tick)); // R3
    AST_FLAG_RISE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[0]) |-> $past(state_q == SEQ_COMPARE)); // R3
    AST_IRQ0_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q == '0) |-> irq0_n); // R9
endmodule

// File: tb/tb_alarm_irq_ctrl.sv
module tb_alarm_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] tm_sec = 8'h00, tm_min = 8'h00, tm_hour = 8'h00, tm_day = 8'h01;
    logic       reg_wr = 1'b0, reg_ptr_load = 1'b0;
    logic [4:0] reg_addr = 5'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sq_in = 1'b0;
    logic       irq0_n, irq1_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    alarm_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour), .tm_day(tm_day),
        .reg_wr(reg_wr), .reg_ptr_load(reg_ptr_load), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sq_in(sq_in),
        .irq0_n(irq0_n), .irq1_n(irq1_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=0x%0h exp=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit [7:0] m_al [8];
    bit [7:0] m_ctrl = 8'h80;
    bit       m_osf = 1, m_f0 = 0, m_f1 = 0, m_pend = 0;

    function automatic bit m_hit(input int a);
        bit [7:0] tv [4];
        tv[0] = tm_sec; tv[1] = tm_min; tv[2] = tm_hour; tv[3] = tm_day;
        for (int i = 0; i < 4; i++) begin
            bit [7:0] av = m_al[a*4+i];
            if (!av[7] && (av[6:0] != tv[i][6:0])) return 0;
        end
        return 1;
    endfunction

    function automatic int m_rd(input int addr);
        if (addr >= 7 && addr <= 14) return int'(m_al[addr-7]);
        if (addr == 15) return int'(m_ctrl);
        if (addr == 16) return int'({m_osf, 5'b0, m_f1, m_f0});
        return 0;
    endfunction

    function automatic bit m_irq0();
        bit a0 = m_f0 & m_ctrl[0];
        bit a1 = m_f1 & m_ctrl[1];
        return m_ctrl[2] ? !a0 : !(a0 | a1);
    endfunction

    function automatic bit m_irq1();
        if (m_ctrl[3]) return sq_in;
        if (m_ctrl[2]) return !(m_f1 & m_ctrl[1]);
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_al[i] = 8'h00;
            m_ctrl = 8'h80; m_osf = 1; m_f0 = 0; m_f1 = 0; m_pend = 0;
        end else begin
            bit s0, s1, c0, c1, sw;
            s0 = m_pend && m_hit(0);
            s1 = m_pend && m_hit(1);
            sw = reg_wr && (reg_addr == 5'd16);
            c0 = (sw && !reg_wdata[0]) || (reg_ptr_load && reg_addr >= 7 && reg_addr <= 10);
            c1 = (sw && !reg_wdata[1]) || (reg_ptr_load && reg_addr >= 11 && reg_addr <= 14);
            if (s0) m_f0 = 1; else if (c0) m_f0 = 0;
            if (s1) m_f1 = 1; else if (c1) m_f1 = 0;
            if (sw && !reg_wdata[7]) m_osf = 0;
            if (reg_wr && reg_addr >= 7 && reg_addr <= 14) m_al[reg_addr-7] = reg_wdata;
            if (reg_wr && reg_addr == 15) m_ctrl = reg_wdata & 8'hBF;
            m_pend = tick;
        end
        #1;
        if (!done) begin
            chk("R9 model irq0_n", int'(irq0_n), int'(m_irq0()));
            chk("R10 model irq1_n", int'(irq1_n), int'(m_irq1()));
            chk("R2 model rdata", int'(reg_rdata), m_rd(int'(reg_addr)));
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk); reg_wr = 1; reg_addr = 5'(a); reg_wdata = 8'(d);
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic ptr(input int a);
        @(negedge clk); reg_ptr_load = 1; reg_addr = 5'(a);
        @(negedge clk); reg_ptr_load = 0;
    endtask

    task automatic rd_chk(input string tag, input int a, input int exp);
        @(negedge clk); reg_addr = 5'(a); #1;
        chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic pins_chk(input string tag, input int e0, input int e1);
        @(negedge clk); #1;
        chk({tag, " irq0_n"}, int'(irq0_n), e0);
        chk({tag, " irq1_n"}, int'(irq1_n), e1);
    endtask

    task automatic do_tick(input int s, input int m, input int h, input int d);
        @(negedge clk);
        tm_sec = 8'(s); tm_min = 8'(m); tm_hour = 8'(h); tm_day = 8'(d); tick = 1;
        @(negedge clk); tick = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd_chk("R1 ctrl reset", 15, 8'h80);
        rd_chk("R1 status reset", 16, 8'h80);
        pins_chk("R1", 1, 1);
        // R2 register access
        wr(7, 8'h80); wr(8, 8'h80); wr(9, 8'h80); wr(10, 8'h80);
        wr(11, 8'h30); wr(12, 8'h15); wr(13, 8'h12); wr(14, 8'h03);
        rd_chk("R2 alarm0 hours", 9, 8'h80);
        rd_chk("R2 alarm1 day", 14, 8'h03);
        wr(15, 8'h47);
        rd_chk("R2 ctrl bit6", 15, 8'h07);
        rd_chk("R2 unused 0x11", 17, 8'h00);
        rd_chk("R2 unused 0x06", 6, 8'h00);
        wr(16, 8'h00);
        rd_chk("R7 osf cleared", 16, 8'h00);
        // R4 every tick
        do_tick(8'h01, 8'h00, 8'h00, 8'h01);
        rd_chk("R4 mask 1111 fires", 16, 8'h01);
        pins_chk("R9 split alarm0", 0, 1);
        // R7 write-1 keeps, write-0 clears
        wr(16, 8'hFF);
        rd_chk("R7 write 1 keeps", 16, 8'h01);
        wr(16, 8'hFE);
        rd_chk("R7 write 0 clears", 16, 8'h00);
        // R3 no tick, no re-trigger
        repeat (4) @(negedge clk);
        rd_chk("R3 no tick no flag", 16, 8'h00);
        // R5 mask patterns
        wr(7, 8'h25);
        do_tick(8'h24, 8'h00, 8'h00, 8'h01);
        rd_chk("R5 sec mismatch", 16, 8'h00);
        do_tick(8'h25, 8'h59, 8'h00, 8'h01);
        rd_chk("R5 sec match", 16, 8'h01);
        wr(16, 8'h00);
        wr(8, 8'h10);
        do_tick(8'h25, 8'h11, 8'h00, 8'h01);
        rd_chk("R5 min mismatch", 16, 8'h00);
        do_tick(8'h25, 8'h10, 8'h07, 8'h01);
        rd_chk("R5 min+sec match", 16, 8'h01);
        wr(16, 8'h00);
        wr(9, 8'h07);
        do_tick(8'h25, 8'h10, 8'h08, 8'h01);
        rd_chk("R5 hour mismatch", 16, 8'h00);
        do_tick(8'h25, 8'h10, 8'h07, 8'h02);
        rd_chk("R5 hour match", 16, 8'h01);
        wr(16, 8'h00);
        wr(10, 8'h05);
        do_tick(8'h25, 8'h10, 8'h07, 8'h04);
        rd_chk("R5 day mismatch", 16, 8'h00);
        do_tick(8'h25, 8'h10, 8'h07, 8'h05);
        rd_chk("R5 day match", 16, 8'h01);
        wr(16, 8'h00);
        // R6 flag regardless of enable
        wr(15, 8'h05);
        do_tick(8'h30, 8'h15, 8'h12, 8'h03);
        rd_chk("R6 flag1 without enable", 16, 8'h02);
        pins_chk("R6 masked", 1, 1);
        wr(15, 8'h07);
        pins_chk("R9 split alarm1", 1, 0);
        wr(15, 8'h03);
        pins_chk("R10 shared", 0, 1);
        // R8 pointer clears
        do_tick(8'h25, 8'h10, 8'h07, 8'h05);
        rd_chk("R8 both set", 16, 8'h03);
        ptr(11);
        rd_chk("R8 ptr alarm1", 16, 8'h01);
        ptr(9);
        rd_chk("R8 ptr alarm0", 16, 8'h00);
        pins_chk("R10 released", 1, 1);
        // R11 square wave
        wr(15, 8'h0F);
        @(negedge clk); sq_in = 0;
        pins_chk("R11 sq low", 1, 0);
        @(negedge clk); sq_in = 1;
        pins_chk("R11 sq high", 1, 1);
        wr(15, 8'h07);
        // R12 set beats clear
        @(negedge clk);
        tm_sec = 8'h25; tm_min = 8'h10; tm_hour = 8'h07; tm_day = 8'h05; tick = 1;
        @(negedge clk); tick = 0; reg_wr = 1; reg_addr = 5'd16; reg_wdata = 8'h00;
        @(negedge clk); reg_wr = 0;
        rd_chk("R12 set wins", 16, 8'h01);
        // R3 one-shot per tick
        wr(16, 8'h00);
        repeat (5) @(negedge clk);
        rd_chk("R3 no retrigger", 16, 8'h00);
        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL R3 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule